// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is an SPI master that runs one flash command transaction at a time under the control of a byte-wide register bus. Software loads a command byte into a dedicated register and writes a packed pair of byte counts. It writes the outgoing payload through a data port into a sixteen-entry byte FIFO, then sets an execute bit. The engine lowers chip select and shifts out the command byte, then each payload byte. It then clocks in the requested number of response bytes and releases chip select.

Response bytes go into the same FIFO, in the entries directly after the payload. Software reads them through the same data port. To reach them it first clears the FIFO pointer and then performs one discarded read for each payload byte. The serial clock is the system clock divided by a fixed parameter. The register bus reads combinationally, and its strobes take effect on the next clock edge.

Top module: `sfc_engine`

## Requirements
- R1: The byte held at register offset 0x0 is always the first byte shifted out of each transaction, and it never passes through the FIFO.
- R2: Register offset 0x1 holds the payload count in bits 3:0 and the receive count in bits 7:4, and it reads back as written. A payload count above 8 is treated as 8.
- R3: Writing a 1 to bit 0 of offset 0x2 while idle starts a transaction. While the engine is busy, bit 0 of offset 0x2 and bit 7 of offset 0x3 read 1. Both read 0 when it is idle.
- R4: Writing a 1 to bit 4 of offset 0x2 sets the FIFO pointer to 0, including while busy. Offset 0xD returns the pointer in bits 3:0, with the upper bits 0.
- R5: Every read or write strobe at offset 0xC accesses the FIFO entry at the pointer and then advances the pointer by one, wrapping from 15 to 0.
- R6: After the command byte, the engine sends the payload bytes from FIFO entries 0 upward. During the receive phase it sends 0x00 filler bytes.
- R7: Received bytes are written into the FIFO in consecutive entries that begin at the entry after the last payload byte, with the index wrapping at 16.
- R8: When the payload count is 0, the engine receives one byte fewer than the receive field; a receive field of 0 gives no received byte.
- R9: The serial interface runs in mode 0, most significant bit first. SCK is low whenever chip select is high. MOSI holds steady across each rising SCK edge. Chip select stays low for 16·N·DIV clock cycles for N bytes in total. Busy then stays set for another 2·DIV cycles with chip select high.
- R10: While busy, writes to offsets 0x0, 0x1 and 0xC are ignored, and a write to 0xC does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Register reads are due in the same cycle as the address. Pointer, register and control effects appear on the following clock edge. Chip select falls on the edge that accepts the execute write, and SCK toggles every DIV cycles from that edge. Chip select rises 16·N·DIV cycles after the start, and busy clears 2·DIV cycles after that. The bench keeps a cycle counter per transaction and compares chip select and SCK on every falling clock edge, after the registers have settled. It checks the bytes captured by its flash model and the FIFO contents read back once busy has cleared.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GUARD = 2'd2
  } seq_state_t;

  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNTS = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_STATUS = 4'h3;
  localparam logic [3:0] OFS_DATA   = 4'hC;
  localparam logic [3:0] OFS_PTR    = 4'hD;

  localparam int CTRL_EXEC_BIT = 0;
  localparam int CTRL_PCLR_BIT = 4;
  localparam int STAT_BUSY_BIT = 7;

endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_clr,
  input  logic          bus_we,
  input  logic          bus_adv,
  input  logic [W-1:0]  bus_wdata,
  input  logic          eng_we,
  input  logic [PW-1:0] eng_idx,
  input  logic [W-1:0]  eng_wdata,
  output logic [PW-1:0] ptr,
  output logic [W-1:0]  bus_rdata,
  output logic [W-1:0]  eng_rdata
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_clr) begin
      ptr_d = '0;
    end else if (bus_adv) begin
      ptr_d = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (eng_we) begin
      mem[eng_idx] <= eng_wdata;
    end else if (bus_we) begin
      mem[ptr_q] <= bus_wdata;
    end
  end

  assign ptr       = ptr_q;
  assign bus_rdata = mem[ptr_q];
  assign eng_rdata = mem[eng_idx];

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> ptr_q == '0); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_adv && !ptr_clr) |=>
      ptr_q == (($past(ptr_q) == PW'(DEPTH - 1)) ? '0 : $past(ptr_q) + PW'(1))); // R5

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_adv && !ptr_clr) |=> $stable(ptr_q)); // R10

endmodule

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          busy,
  input  logic [PW-1:0] fifo_ptr,
  input  logic [7:0]    fifo_rdata,
  output logic [7:0]    opcode,
  output logic [3:0]    tx_cnt,
  output logic [3:0]    rx_cnt,
  output logic          go,
  output logic          ptr_clr,
  output logic          fifo_we,
  output logic          fifo_adv
);

  logic [7:0] opc_q, opc_d;
  logic [7:0] cnt_q, cnt_d;
  logic       opc_en, cnt_en;
  logic       ctrl_wr;

  assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign go       = ctrl_wr && bus_wdata[CTRL_EXEC_BIT] && !busy;
  assign ptr_clr  = ctrl_wr && bus_wdata[CTRL_PCLR_BIT];
  assign fifo_we  = bus_wr && (bus_addr == OFS_DATA) && !busy;
  assign fifo_adv = fifo_we || (bus_rd && (bus_addr == OFS_DATA));
  assign opc_en   = bus_wr && (bus_addr == OFS_OPCODE) && !busy;
  assign cnt_en   = bus_wr && (bus_addr == OFS_COUNTS) && !busy;

  always_comb begin
    opc_d = opc_q;
    cnt_d = cnt_q;
    if (opc_en) opc_d = bus_wdata;
    if (cnt_en) cnt_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q <= '0;
      cnt_q <= '0;
    end else begin
      opc_q <= opc_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_OPCODE: bus_rdata = opc_q;
      OFS_COUNTS: bus_rdata = cnt_q;
      OFS_CTRL:   bus_rdata[CTRL_EXEC_BIT] = busy;
      OFS_STATUS: bus_rdata[STAT_BUSY_BIT] = busy;
      OFS_DATA:   bus_rdata = fifo_rdata;
      OFS_PTR:    bus_rdata[PW-1:0] = fifo_ptr;
      default:    bus_rdata = '0;
    endcase
  end

  assign opcode = opc_q;
  assign tx_cnt = cnt_q[3:0];
  assign rx_cnt = cnt_q[7:4];

  AST_OPC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> opc_q == $past(opc_q)); // R10

  AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt_q == $past(cnt_q)); // R10

  AST_NO_FIFO_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fifo_we); // R10

endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int DIV    = 2,
  parameter int MAX_TX = 8,
  parameter int PW     = 4,
  localparam int DW    = $clog2(2 * DIV) + 1,
  localparam int TW    = $clog2(MAX_TX + 17)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [7:0]    opcode,
  input  logic [3:0]    tx_cnt,
  input  logic [3:0]    rx_cnt,
  input  logic [7:0]    fifo_rdata,
  output logic          fifo_we,
  output logic [PW-1:0] fifo_idx,
  output logic [7:0]    fifo_wdata,
  output logic          busy,
  output logic          cs_n,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);

  seq_state_t    st_q, st_d;
  logic [DW-1:0] div_q, div_d;
  logic [2:0]    bit_q, bit_d;
  logic [TW-1:0] byte_q, byte_d;
  logic [TW-1:0] tot_q, tot_d;
  logic [TW-1:0] ntx_q, ntx_d;
  logic [PW-1:0] idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic          smp_q, smp_d;
  logic          sck_q, sck_d;
  logic          cs_q, cs_d;
  logic [3:0]    eff_tx, eff_rx;
  logic [PW-1:0] idx_inc;

  assign eff_tx  = (tx_cnt > 4'(MAX_TX)) ? 4'(MAX_TX) : tx_cnt;
  assign eff_rx  = (eff_tx != 4'd0) ? rx_cnt :
                   ((rx_cnt == 4'd0) ? 4'd0 : rx_cnt - 4'd1);
  assign idx_inc = idx_q + PW'(1);

  always_comb begin
    st_d       = st_q;
    div_d      = div_q;
    bit_d      = bit_q;
    byte_d     = byte_q;
    tot_d      = tot_q;
    ntx_d      = ntx_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    smp_d      = smp_q;
    sck_d      = sck_q;
    cs_d       = cs_q;
    fifo_we    = 1'b0;
    fifo_wdata = {sh_q[6:0], smp_q};
    unique case (st_q)
      SEQ_IDLE: begin
        if (go) begin
          st_d   = SEQ_SHIFT;
          sh_d   = opcode;
          bit_d  = 3'd7;
          byte_d = '0;
          div_d  = '0;
          sck_d  = 1'b0;
          cs_d   = 1'b0;
          idx_d  = '0;
          ntx_d  = TW'(eff_tx);
          tot_d  = TW'(1) + TW'(eff_tx) + TW'(eff_rx);
        end
      end
      SEQ_SHIFT: begin
        if (div_q == DW'(DIV - 1)) begin
          div_d = '0;
          sck_d = ~sck_q;
          if (!sck_q) begin
            smp_d = miso;
          end else begin
            sh_d = {sh_q[6:0], smp_q};
            if (bit_q == 3'd0) begin
              if (byte_q > ntx_q) begin
                fifo_we = 1'b1;
                idx_d   = idx_inc;
              end
              if (byte_q == tot_q - TW'(1)) begin
                st_d = SEQ_GUARD;
                cs_d = 1'b1;
              end else begin
                byte_d = byte_q + TW'(1);
                bit_d  = 3'd7;
                if (byte_q < ntx_q) begin
                  sh_d  = fifo_rdata;
                  idx_d = idx_inc;
                end else begin
                  sh_d = 8'h00;
                end
              end
            end else begin
              bit_d = bit_q - 3'd1;
            end
          end
        end else begin
          div_d = div_q + DW'(1);
        end
      end
      SEQ_GUARD: begin
        if (div_q == DW'(2 * DIV - 1)) begin
          div_d = '0;
          st_d  = SEQ_IDLE;
        end else begin
          div_d = div_q + DW'(1);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      div_q  <= '0;
      bit_q  <= '0;
      byte_q <= '0;
      tot_q  <= '0;
      ntx_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      smp_q  <= 1'b0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      st_q   <= st_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      tot_q  <= tot_d;
      ntx_q  <= ntx_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      smp_q  <= smp_d;
      sck_q  <= sck_d;
      cs_q   <= cs_d;
    end
  end

  assign busy     = (st_q != SEQ_IDLE);
  assign cs_n     = cs_q;
  assign sck      = sck_q;
  assign mosi     = sh_q[7];
  assign fifo_idx = idx_q;

  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sck_q); // R9

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_q); // R9

  AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> $stable(sh_q[7])); // R9

  AST_START_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> (!cs_q && busy)); // R3

  AST_GUARD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> busy); // R9

endmodule

// File: rtl/sfc_engine.sv
module sfc_engine #(
  parameter int DIV        = 2,
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_TX     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int PW = $clog2(FIFO_DEPTH);

  logic [1:0]    rst_pipe;
  logic          rst_s_n;
  logic          busy, go, ptr_clr, bus_fifo_we, bus_fifo_adv;
  logic [7:0]    opcode;
  logic [3:0]    tx_cnt, rx_cnt;
  logic [PW-1:0] fifo_ptr, eng_idx;
  logic [7:0]    fifo_bus_rdata, fifo_eng_rdata, eng_wdata;
  logic          eng_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s_n = rst_pipe[1];

  sfc_regs #(.PW(PW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .fifo_ptr   (fifo_ptr),
    .fifo_rdata (fifo_bus_rdata),
    .opcode     (opcode),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .go         (go),
    .ptr_clr    (ptr_clr),
    .fifo_we    (bus_fifo_we),
    .fifo_adv   (bus_fifo_adv)
  );

  sfc_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .ptr_clr   (ptr_clr),
    .bus_we    (bus_fifo_we),
    .bus_adv   (bus_fifo_adv),
    .bus_wdata (bus_wdata),
    .eng_we    (eng_we),
    .eng_idx   (eng_idx),
    .eng_wdata (eng_wdata),
    .ptr       (fifo_ptr),
    .bus_rdata (fifo_bus_rdata),
    .eng_rdata (fifo_eng_rdata)
  );

  sfc_seq #(.DIV(DIV), .MAX_TX(MAX_TX), .PW(PW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .go         (go),
    .opcode     (opcode),
    .tx_cnt     (tx_cnt),
    .rx_cnt     (rx_cnt),
    .fifo_rdata (fifo_eng_rdata),
    .fifo_we    (eng_we),
    .fifo_idx   (eng_idx),
    .fifo_wdata (eng_wdata),
    .busy       (busy),
    .cs_n       (spi_cs_n),
    .sck        (spi_sck),
    .mosi       (spi_mosi),
    .miso       (spi_miso)
  );

endmodule

// File: tb/sim_sfc_engine.sv
module sim_sfc_engine;

  localparam int DIV = 2;

  logic       clk;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       spi_cs_n, spi_sck, spi_mosi, spi_miso;

  int checks = 0;
  int errors = 0;
  bit armed  = 0;

  sfc_engine #(.DIV(DIV), .FIFO_DEPTH(16), .MAX_TX(8)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // flash model: returns resp bits, captures MOSI bytes
  logic [7:0] resp [32];
  logic [7:0] cap  [32];
  int rbit  = 0;
  int ncap  = 0;
  int cbits = 0;
  logic [7:0] cbyte = '0;

  assign spi_miso = resp[(rbit / 8) % 32][7 - (rbit % 8)];

  always @(negedge spi_cs_n) begin
    rbit  = 0;
    ncap  = 0;
    cbits = 0;
  end

  always @(posedge spi_sck) begin
    cbyte = {cbyte[6:0], spi_mosi};
    cbits++;
    rbit++;
    if (cbits % 8 == 0) begin
      cap[ncap % 32] = cbyte;
      ncap++;
    end
  end

  // cycle reference model of select and serial clock
  bit         m_busy = 0;
  int         m_t    = 0;
  int         m_sel  = 0;
  int         m_end  = 0;
  logic [7:0] m_cnt  = '0;

  function automatic int eff_tx(input int f);
    return (f > 8) ? 8 : f;
  endfunction

  function automatic int eff_rx(input int ftx, input int frx);
    if (eff_tx(ftx) != 0) return frx;
    return (frx == 0) ? 0 : frx - 1;
  endfunction

  always @(posedge clk) begin
    if (armed) begin
      bit was;
      was = m_busy;
      if (m_busy) begin
        m_t++;
        if (m_t == m_end) m_busy = 0;
      end
      if (!was && bus_wr && bus_addr == 4'h1) m_cnt = bus_wdata;
      if (!was && bus_wr && bus_addr == 4'h2 && bus_wdata[0]) begin
        int n;
        n      = 1 + eff_tx(int'(m_cnt[3:0])) + eff_rx(int'(m_cnt[3:0]), int'(m_cnt[7:4]));
        m_sel  = 16 * n * DIV;
        m_end  = m_sel + 2 * DIV;
        m_t    = 0;
        m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      logic cs_e, sck_e;
      cs_e  = !(m_busy && m_t < m_sel);
      sck_e = cs_e ? 1'b0 : 1'((m_t / DIV) % 2);
      chk(spi_cs_n === cs_e, "R9 cs_n per cycle", int'(spi_cs_n), int'(cs_e));
      chk(spi_sck === sck_e, "R9 sck per cycle", int'(spi_sck), int'(sck_e));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    int guard = 0;
    do begin
      rd(4'h3, v);
      guard++;
    end while (v[7] && guard < 5000);
  endtask

  task automatic xfer(input logic [7:0] op, input int ftx, input int frx, input int seed);
    int etx, erx;
    logic [7:0] pay [8];
    logic [7:0] v;
    string rq;
    etx = eff_tx(ftx);
    erx = eff_rx(ftx, frx);
    for (int i = 0; i < 32; i++) resp[i] = 8'(seed * 31 + i * 57 + 3);
    wr(4'h1, {4'(frx), 4'(ftx)});
    wr(4'h0, op);
    wr(4'h2, 8'h10);
    for (int i = 0; i < etx; i++) begin
      pay[i] = 8'(seed + i * 13 + 1);
      wr(4'hC, pay[i]);
    end
    wr(4'h2, 8'h10);
    wr(4'h2, 8'h01);
    rd(4'h2, v);
    chk(v[0] == 1'b1, "R3 exec bit reads 1 while busy", int'(v[0]), 1);
    wait_idle();
    rd(4'h2, v);
    chk(v[0] == 1'b0, "R3 exec bit clear when done", int'(v[0]), 0);
    rq = (ftx > 8) ? "R2 clamped byte total" : ((etx == 0) ? "R8 byte total" : "R6 byte total");
    chk(ncap == 1 + etx + erx, rq, ncap, 1 + etx + erx);
    chk(cap[0] == op, "R1 opcode first", int'(cap[0]), int'(op));
    for (int i = 0; i < etx; i++)
      chk(cap[1 + i] == pay[i], "R6 payload order", int'(cap[1 + i]), int'(pay[i]));
    for (int i = 0; i < erx; i++)
      chk(cap[1 + etx + i] == 8'h00, "R6 filler during receive", int'(cap[1 + etx + i]), 0);
    wr(4'h2, 8'h10);
    for (int i = 0; i < etx; i++) rd(4'hC, v);
    for (int k = 0; k < erx; k++) begin
      rd(4'hC, v);
      chk(v == resp[1 + etx + k], (etx == 0) ? "R8 response data" : "R7 response data",
          int'(v), int'(resp[1 + etx + k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, p0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_wdata = '0;
    rst_n     = 1'b1;
    #2 rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n  = 1'b1;
    repeat (4) @(posedge clk);
    armed = 1;

    // reset state
    rd(4'h3, v);
    chk(v == 8'h00, "R3 idle status after reset", int'(v), 0);
    rd(4'hD, v);
    chk(v == 8'h00, "R4 pointer after reset", int'(v), 0);
    chk(spi_cs_n === 1'b1, "R9 cs_n after reset", int'(spi_cs_n), 1);

    // counts register read back
    wr(4'h1, 8'h5A);
    rd(4'h1, v);
    chk(v == 8'h5A, "R2 counts read back", int'(v), 8'h5A);

    // pointer and data port
    wr(4'h2, 8'h10);
    wr(4'hC, 8'h11);
    wr(4'hC, 8'h22);
    wr(4'hC, 8'h33);
    rd(4'hD, v);
    chk(v == 8'h03, "R4 pointer after three writes", int'(v), 3);
    wr(4'h2, 8'h10);
    rd(4'hD, v);
    chk(v == 8'h00, "R4 pointer cleared", int'(v), 0);
    rd(4'hC, v);
    chk(v == 8'h11, "R5 data port entry 0", int'(v), 8'h11);
    rd(4'hC, v);
    chk(v == 8'h22, "R5 data port entry 1", int'(v), 8'h22);
    wr(4'h2, 8'h10);
    for (int i = 0; i < 17; i++) rd(4'hC, v);
    rd(4'hD, v);
    chk(v == 8'h01, "R5 pointer wraps at 16", int'(v), 1);

    // transactions
    xfer(8'h05, 0, 0, 1);
    xfer(8'h9F, 0, 4, 2);
    xfer(8'h03, 3, 4, 3);
    xfer(8'h02, 8, 8, 4);
    xfer(8'h0B, 12, 2, 5);
    xfer(8'hAB, 8, 15, 6);

    // writes while busy
    wr(4'h1, 8'h40);
    wr(4'h0, 8'h9F);
    wr(4'h2, 8'h10);
    rd(4'hD, p0);
    wr(4'h2, 8'h01);
    rd(4'h3, v);
    chk(v[7] == 1'b1, "R3 busy flag in status", int'(v[7]), 1);
    wr(4'h0, 8'h55);
    wr(4'h1, 8'h77);
    wr(4'hC, 8'hEE);
    rd(4'hD, v);
    chk(v == p0, "R10 pointer unmoved by busy write", int'(v), int'(p0));
    wait_idle();
    rd(4'h0, v);
    chk(v == 8'h9F, "R10 opcode kept", int'(v), 8'h9F);
    rd(4'h1, v);
    chk(v == 8'h40, "R10 counts kept", int'(v), 8'h40);
    chk(cap[0] == 8'h9F, "R10 opcode on wire kept", int'(cap[0]), 8'h9F);
    wr(4'h2, 8'h10);
    rd(4'hC, v);
    chk(v == resp[1], "R10 fifo entry not overwritten", int'(v), int'(resp[1]));

    repeat (4) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule